// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on one output line. A frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. A bit-rate tick, pulsed for one clock per bit period by logic outside the block, sets how long each bit lasts. Every frame begins on a tick, so every bit, the start bit included, lasts exactly one tick period.

Software-style strobes load a configuration word (character size, parity mode, stop count) and a separate holding bit that supplies the ninth data bit. Writing the low data byte places the byte and the current holding bit into a one-deep buffer. The buffer moves into the serializer when a frame begins. A buffer-empty flag shows when another byte may be written. A done flag shows that the line has gone idle with nothing left to send. The serializer copies the configuration when it loads each frame, so a change made during a frame applies from the next frame.

The serializer is a state machine with states IDLE, START, DATA, PARITY, STOP1 and STOP2. It moves as follows:
- IDLE to START on a tick with the buffer full. This is the load.
- START to DATA on a tick.
- DATA to PARITY, or to STOP1 when parity is off, on the tick that ends the last data bit.
- PARITY to STOP1 on a tick.
- STOP1 to STOP2 on a tick when two stop bits are set.
- From the final stop state to START on a tick when the buffer is full. This is a back-to-back load.
- From the final stop state to IDLE on a tick when the buffer is empty.

Top module: `async_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1. After reset, `buf_empty` is 1 and `tx_done` is 0.
- R2: A frame starts only on a clock edge where `baud_tick` is 1. It is a 0 start bit, then the data bits least significant first, then the stop bits at 1. Each bit holds for exactly one tick period, and `tx_line` changes only on edges where `baud_tick` is 1.
- R3: The size code {`cfg_size_hi`,`cfg_size_lo`} selects the number of data bits: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. Every other code gives 8.
- R4: In 9-bit mode, the ninth data bit is the holding bit written through `nbit_we`/`nbit_in`, as it stood when `data_we` was accepted. Later writes to the holding bit do not change a byte that is already buffered.
- R5: The `cfg_parity` code selects the parity bit: 00 gives no parity, 01 is reserved and gives no parity, 10 gives even parity and 11 gives odd parity. The parity bit covers only the data bits sent and follows the last data bit. Even parity is the XOR of the data bits, and odd parity is its inverse.
- R6: `cfg_two_stop` = 0 gives one stop bit and 1 gives two stop bits.
- R7: The reset configuration is size code 011, parity code 00 and one stop bit. This makes an 8-bit frame with no parity and one stop bit.
- R8: A configuration write made during a frame does not alter that frame. It applies from the next frame loaded.
- R9: A `data_we` while `buf_empty` is 1 is accepted, and `buf_empty` drops on the next edge. A `data_we` while `buf_empty` is 0 is ignored. `buf_empty` rises on the edge where the buffered byte loads into the serializer.
- R10: `tx_done` rises on the edge that ends the last stop bit when the buffer is empty. An accepted data write clears it. When the buffer is full at the end of a frame, the next start bit follows at once with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock pulse per bit period |
| cfg_we | input | 1 | Strobe that loads the configuration fields |
| cfg_size_hi | input | 1 | High bit of the character size code |
| cfg_size_lo | input | 2 | Low bits of the character size code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Stop-bit count select |
| nbit_we | input | 1 | Strobe that loads the ninth-bit holding register |
| nbit_in | input | 1 | Ninth data bit value |
| data_we | input | 1 | Strobe that writes the low data byte |
| data_in | input | 8 | Low data byte |
| tx_line | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | The data buffer can take a byte |
| tx_done | output | 1 | Last frame finished and nothing is buffered |

## Verification
A wrong bit count or wrong state in the serializer shows on `tx_line` within the frame itself. A sampled bit differs from its expected value, or the line is not back high one tick period after the expected last stop bit. A stale configuration copy or a badly latched ninth bit produces a whole frame of the wrong length or parity, so it is caught the first time that frame is sent. Buffer flag errors show on `buf_empty` one clock after the write or the load. A missed back-to-back start shows as an idle bit where a start bit was due.

// File: rtl/atx_pkg.sv
package atx_pkg;
    localparam int LOW_W     = 8;
    localparam int FRAME_MAX = LOW_W + 1;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } atx_state_e;

    typedef struct packed {
        logic [2:0] size_code;
        logic [1:0] par_mode;
        logic       two_stop;
    } atx_cfg_t;

    function automatic logic [CNT_W-1:0] char_len(input logic [2:0] code);
        logic [CNT_W-1:0] len;
        case (code)
            3'b000:  len = CNT_W'(5);
            3'b001:  len = CNT_W'(6);
            3'b010:  len = CNT_W'(7);
            3'b111:  len = CNT_W'(9);
            default: len = CNT_W'(8);
        endcase
        return len;
    endfunction

    function automatic logic xor_over(input logic [FRAME_MAX-1:0] bits,
                                      input logic [CNT_W-1:0] len);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < FRAME_MAX; i++) begin
            if (i < int'(len)) acc = acc ^ bits[i];
        end
        return acc;
    endfunction
endpackage

// File: rtl/atx_cfg_regs.sv
module atx_cfg_regs
    import atx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  atx_cfg_t cfg_in,
    input  logic     nbit_we,
    input  logic     nbit_in,
    output atx_cfg_t cfg_q,
    output logic     nbit_q
);
    localparam atx_cfg_t CFG_RESET = '{size_code: 3'b011, par_mode: 2'b00, two_stop: 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RESET;
            nbit_q <= 1'b0;
        end else begin
            if (cfg_we)  cfg_q  <= cfg_in;
            if (nbit_we) nbit_q <= nbit_in;
        end
    end
endmodule

// File: rtl/atx_hold_buf.sv
module atx_hold_buf
    import atx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LOW_W-1:0]     wr_low,
    input  logic                 wr_ninth,
    input  logic                 pop,
    output logic                 full,
    output logic                 accept,
    output logic [FRAME_MAX-1:0] frame_q
);
    assign accept = wr_en && !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full    <= 1'b0;
            frame_q <= '0;
        end else if (accept) begin
            full    <= 1'b1;
            frame_q <= {wr_ninth, wr_low};
        end else if (pop) begin
            full    <= 1'b0;
        end
    end
endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
    import atx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 avail,
    input  logic [FRAME_MAX-1:0] frame_in,
    input  atx_cfg_t             cfg,
    output logic                 tx,
    output logic                 load,
    output logic                 frame_end,
    output logic                 busy
);
    atx_state_e             state, state_nx;
    logic [FRAME_MAX-1:0]   shreg;
    logic [CNT_W-1:0]       len_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   par_en_q;
    logic                   par_bit_q;
    logic                   two_stop_q;
    logic                   last_data;
    logic [CNT_W-1:0]       new_len;

    assign last_data = (cnt_q == len_q - CNT_W'(1));
    assign new_len   = char_len(cfg.size_code);

    // frame boundary events
    always_comb begin
        frame_end = tick && ((state == ST_STOP1 && !two_stop_q) || state == ST_STOP2);
        load      = tick && avail && (state == ST_IDLE || frame_end);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (tick && avail) state_nx = ST_START;
            ST_START:  if (tick) state_nx = ST_DATA;
            ST_DATA:   if (tick && last_data) state_nx = par_en_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (tick) state_nx = ST_STOP1;
            ST_STOP1:  if (tick) state_nx = two_stop_q ? ST_STOP2 : (avail ? ST_START : ST_IDLE);
            ST_STOP2:  if (tick) state_nx = avail ? ST_START : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame datapath: snapshot of data and configuration at load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            len_q      <= CNT_W'(8);
            cnt_q      <= '0;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            two_stop_q <= 1'b0;
        end else if (load) begin
            shreg      <= frame_in;
            len_q      <= new_len;
            cnt_q      <= '0;
            par_en_q   <= cfg.par_mode[1];
            par_bit_q  <= xor_over(frame_in, new_len) ^ cfg.par_mode[0];
            two_stop_q <= cfg.two_stop;
        end else if (tick && state == ST_DATA) begin
            shreg      <= shreg >> 1;
            cnt_q      <= cnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy = (state != ST_IDLE);
        unique case (state)
            ST_IDLE:   tx = 1'b1;
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = shreg[0];
            ST_PARITY: tx = par_bit_q;
            ST_STOP1:  tx = 1'b1;
            ST_STOP2:  tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/async_serial_tx.sv
module async_serial_tx
    import atx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             cfg_we,
    input  logic             cfg_size_hi,
    input  logic [1:0]       cfg_size_lo,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_two_stop,
    input  logic             nbit_we,
    input  logic             nbit_in,
    input  logic             data_we,
    input  logic [LOW_W-1:0] data_in,
    output logic             tx_line,
    output logic             buf_empty,
    output logic             tx_done
);
    atx_cfg_t             cfg_wr;
    atx_cfg_t             cfg_q;
    logic                 nbit_q;
    logic                 buf_full;
    logic                 wr_accept;
    logic [FRAME_MAX-1:0] buf_frame;
    logic                 frame_load;
    logic                 frame_end;
    logic                 ser_busy;

    assign cfg_wr = '{size_code: {cfg_size_hi, cfg_size_lo},
                      par_mode:  cfg_parity,
                      two_stop:  cfg_two_stop};

    atx_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_in  (cfg_wr),
        .nbit_we (nbit_we),
        .nbit_in (nbit_in),
        .cfg_q   (cfg_q),
        .nbit_q  (nbit_q)
    );

    atx_hold_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_we),
        .wr_low   (data_in),
        .wr_ninth (nbit_q),
        .pop      (frame_load),
        .full     (buf_full),
        .accept   (wr_accept),
        .frame_q  (buf_frame)
    );

    atx_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .avail     (buf_full),
        .frame_in  (buf_frame),
        .cfg       (cfg_q),
        .tx        (tx_line),
        .load      (frame_load),
        .frame_end (frame_end),
        .busy      (ser_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      tx_done <= 1'b0;
        else if (wr_accept)              tx_done <= 1'b0;
        else if (frame_end && !buf_full) tx_done <= 1'b1;
    end

    assign buf_empty = !buf_full;
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic data_we,
    input logic tx_line,
    input logic buf_empty,
    input logic tx_done,
    input logic load,
    input logic busy
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_line != $past(tx_line)) |-> $past(baud_tick));

    assert_frame_starts_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(baud_tick));

    assert_write_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && data_we) |=> !buf_empty);

    assert_empty_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(load));

    assert_done_means_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!busy && buf_empty && tx_line));
endmodule

bind async_serial_tx atx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .data_we   (data_we),
    .tx_line   (tx_line),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .load      (frame_load),
    .busy      (ser_busy)
);

// File: tb/sim_async_serial_tx.sv
module sim_async_serial_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_size_hi = 1'b0;
    logic [1:0] cfg_size_lo = 2'b00;
    logic [1:0] cfg_parity = 2'b00;
    logic       cfg_two_stop = 1'b0;
    logic       nbit_we = 1'b0;
    logic       nbit_in = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       tx_line, buf_empty, tx_done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int div      = 0;

    always #4 clk = ~clk;

    // bit-rate tick: one clock high in every four
    always @(negedge clk) begin
        if (!rst_n) begin
            div       <= 0;
            baud_tick <= 1'b0;
        end else begin
            div       <= (div == 3) ? 0 : div + 1;
            baud_tick <= (div == 2);
        end
    end

    async_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_we(cfg_we), .cfg_size_hi(cfg_size_hi), .cfg_size_lo(cfg_size_lo),
        .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .nbit_we(nbit_we), .nbit_in(nbit_in),
        .data_we(data_we), .data_in(data_in),
        .tx_line(tx_line), .buf_empty(buf_empty), .tx_done(tx_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void build(input logic [8:0] d, input logic [2:0] sc,
                                  input logic [1:0] pm, input logic ts,
                                  output logic [12:0] bits, output int n);
        int  len;
        logic par;
        case (sc)
            3'b000:  len = 5;
            3'b001:  len = 6;
            3'b010:  len = 7;
            3'b111:  len = 9;
            default: len = 8;
        endcase
        bits = '1;
        bits[0] = 1'b0;
        n = 1;
        par = 1'b0;
        for (int i = 0; i < len; i++) begin
            bits[n] = d[i];
            par = par ^ d[i];
            n = n + 1;
        end
        if (pm == 2'b10) begin bits[n] = par;  n = n + 1; end
        if (pm == 2'b11) begin bits[n] = ~par; n = n + 1; end
        n = n + (ts ? 2 : 1);
    endfunction

    // strobe tasks: called at a negedge, each uses one clock
    task automatic put_cfg(input logic [2:0] sc, input logic [1:0] pm, input logic ts);
        cfg_size_hi = sc[2]; cfg_size_lo = sc[1:0]; cfg_parity = pm; cfg_two_stop = ts;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_nbit(input logic b);
        nbit_in = b; nbit_we = 1'b1;
        @(negedge clk);
        nbit_we = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] d);
        data_in = d; data_we = 1'b1;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic wait_start(input string req);
        int k;
        k = 0;
        while (tx_line !== 1'b0 && k < 400) begin
            @(negedge clk);
            k++;
        end
        check(tx_line === 1'b0, req, "start bit seen", 32'(tx_line), 0);
    endtask

    task automatic read_bits(input logic [12:0] exp, input int n, input int first_idx,
                             input int first_wait, input string req, input string what);
        logic [12:0] got;
        logic [12:0] mask;
        got = '1;
        got[0] = 1'b0;
        for (int i = first_idx; i < n; i++) begin
            repeat ((i == first_idx) ? first_wait : 4) @(negedge clk);
            got[i] = tx_line;
        end
        mask = 13'((1 << n) - 1);
        check((got & mask) === (exp & mask), req, what, 32'(got & mask), 32'(exp & mask));
    endtask

    task automatic check_idle_done(input string req, input string what);
        repeat (4) @(negedge clk);
        check(tx_line === 1'b1 && tx_done === 1'b1, req, what,
              {30'd0, tx_line, tx_done}, 32'h3);
    endtask

    task automatic run_frame(input bit do_cfg, input logic [8:0] d, input logic [2:0] sc,
                             input logic [1:0] pm, input logic ts, input string req);
        logic [12:0] exp;
        int n;
        build(d, sc, pm, ts, exp, n);
        if (do_cfg) put_cfg(sc, pm, ts);
        put_nbit(d[8]);
        put_data(d[7:0]);
        check(buf_empty === 1'b0, "R9", "buffer full after write", 32'(buf_empty), 0);
        check(tx_done === 1'b0, "R10", "done cleared by write", 32'(tx_done), 0);
        wait_start(req);
        check(buf_empty === 1'b1, "R9", "buffer empty at load", 32'(buf_empty), 1);
        read_bits(exp, n, 1, 4, req, "frame bits");
        check_idle_done("R10", "idle and done after frame");
    endtask

    task automatic t_reset();
        check(tx_line === 1'b1, "R1", "line idle after reset", 32'(tx_line), 1);
        check(buf_empty === 1'b1, "R1", "buffer empty after reset", 32'(buf_empty), 1);
        check(tx_done === 1'b0, "R1", "done low after reset", 32'(tx_done), 0);
    endtask

    task automatic t_default();
        // R7 default 8N1 and R2 framing, no config write
        run_frame(1'b0, 9'h0A5, 3'b011, 2'b00, 1'b0, "R7");
    endtask

    task automatic t_sizes_parity();
        run_frame(1'b1, 9'h013, 3'b000, 2'b10, 1'b0, "R3");  // 5 bits, even (R5)
        run_frame(1'b1, 9'h02D, 3'b001, 2'b01, 1'b0, "R5");  // 6 bits, reserved code = none
        run_frame(1'b1, 9'h055, 3'b010, 2'b11, 1'b0, "R5");  // 7 bits, odd
        run_frame(1'b1, 9'h0C3, 3'b100, 2'b00, 1'b1, "R3");  // code 100 -> 8 bits, two stops (R6)
        run_frame(1'b1, 9'h13C, 3'b111, 2'b00, 1'b1, "R6");  // 9 bits (R4), two stops
    endtask

    task automatic t_queue();
        logic [12:0] ea, eb;
        int na, nb;
        build(9'h00F, 3'b111, 2'b10, 1'b1, ea, na);
        build(9'h181, 3'b111, 2'b10, 1'b1, eb, nb);
        put_cfg(3'b111, 2'b10, 1'b1);
        put_nbit(1'b0);
        put_data(8'h0F);
        wait_start("R2");
        put_nbit(1'b1);
        put_data(8'h81);
        check(buf_empty === 1'b0, "R9", "second byte buffered", 32'(buf_empty), 0);
        put_nbit(1'b0);                // R4: must not reach buffered byte
        put_data(8'hFF);               // R9: ignored, buffer full
        read_bits(ea, na, 1, 0, "R4", "first queued frame");
        read_bits(eb, nb, 0, 4, "R10", "back-to-back frame, ninth bit latched (R4)");
        check_idle_done("R9", "write while full ignored");
    endtask

    task automatic t_midcfg();
        logic [12:0] e;
        int n;
        build(9'h03C, 3'b011, 2'b00, 1'b0, e, n);
        put_cfg(3'b011, 2'b00, 1'b0);
        put_nbit(1'b0);
        put_data(8'h3C);
        wait_start("R8");
        put_cfg(3'b000, 2'b10, 1'b1);
        read_bits(e, n, 1, 3, "R8", "frame unchanged by mid-frame config");
        check_idle_done("R8", "idle after unchanged frame");
        run_frame(1'b0, 9'h00B, 3'b000, 2'b10, 1'b1, "R8");
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_default();
        t_sizes_parity();
        t_queue();
        t_midcfg();
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule